// File: doc/BRIEF.md
# DS3 Overhead Error Injector

This block sits in a DS3 transmit path after the overhead bits have been generated. It corrupts chosen overhead bits of the serial stream so that a far end or a test set can check its error detection. There are four kinds of corruption: framing, payload parity (P-bits), path parity (the C-bits of subframe 3) and far-end block error (the C-bits of subframe 4). Each kind has its own enable. Each kind can run in continuous mode, which corrupts every opportunity, or in single mode, which corrupts the next opportunity after a request.

The framing kind has four variants. Two of them turn one request into a burst. The subframe burst inverts every F-bit of one subframe. The multiframe burst inverts the first M-bit of two frames in a row.

The block finds overhead positions from an external position bus or from an internal bit counter that a frame-sync pulse realigns. A request comes from a per-kind register pulse or from a shared manual input, and a select bit chooses between them. Each request is caught on its rising edge and held pending until the matching opportunity arrives.

Top module: `ds3_oh_errinj`

## Requirements
- R1: Framing mode 0 (single F-bit) inverts one F-bit. An F-bit is an overhead bit (bit 0) of an odd block (1, 3, 5, 7) in any subframe.
- R2: Framing mode 1 (single M-bit) inverts one M-bit. An M-bit is bit 0 of block 0 in subframe 4, 5 or 6. The M-bit after it passes unchanged.
- R3: Framing mode 2 (subframe burst) waits for an F1 bit (block 1), then inverts F1 to F4 of that subframe (blocks 1, 3, 5, 7). F-bits seen before that F1 and after that F4 pass unchanged.
- R4: Framing mode 3 (multiframe burst) inverts the M1 bit (subframe 4, block 0) in each of the next two frames. The third M1 passes unchanged.
- R5: A P-bit error inverts both P1 (subframe 2, block 0) and P2 (subframe 3, block 0) of one frame.
- R6: A C-bit parity error inverts the C-bits of subframe index 2 (bit 0 of blocks 2, 4 and 6), all within one frame.
- R7: A far-end block error forces the C-bits of subframe index 3 (bit 0 of blocks 2, 4 and 6) to zero, all within one frame.
- R8: When a kind's continuous bit is set, every opportunity of that kind is corrupted. No request is needed.
- R9: When `req_src_sel` is 0, requests come from `reg_req[k]`. When it is 1, they come from `man_req`. The source that is not selected has no effect. The kind index k is 0 for framing, 1 for P-bit, 2 for C-bit parity and 3 for far-end block error.
- R10: In single mode, a rising edge of the request is held pending until its opportunity is reached. A second edge that arrives while one is pending or in progress is ignored.
- R11: A kind whose `err_en` bit is 0 alters no bit.
- R12: When `ext_pos_en` is 1, the position is taken from the ext bus: subframe 0..6, block 0..7, bit 0..84, with overhead at bit 0. When `ext_pos_en` is 0, an internal counter supplies the position. A `frame_sync` pulse marks the current bit as subframe 0, block 0, bit 0.
- R13: `dout` is registered one cycle after `din`. Bits that are not targeted pass unchanged. `dout` is 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low reset |
| din | input | 1 | Serial DS3 data in |
| ext_pos_en | input | 1 | 1: use the ext position bus; 0: use the internal counter |
| ext_sub | input | 3 | External subframe index 0..6 |
| ext_blk | input | 3 | External block index 0..7 |
| ext_bit | input | 7 | External bit index within the block, 0..84 |
| frame_sync | input | 1 | Marks the current bit as the first bit of a frame |
| err_en | input | 4 | Per-kind enable |
| err_cont | input | 4 | Per-kind continuous mode |
| fr_mode | input | 2 | Framing variant: 0 F-bit, 1 M-bit, 2 subframe burst, 3 multiframe burst |
| req_src_sel | input | 1 | Request source: 0 register, 1 manual |
| reg_req | input | 4 | Per-kind register request |
| man_req | input | 1 | Manual request, shared by all kinds |
| dout | output | 1 | Serial DS3 data out |

## Verification
The assertions check on every cycle that payload bits pass through with one cycle of delay. They also check that a far-end block hit always yields a zero, that a P-bit hit always flips the bit, that continuous mode flips every P-bit opportunity, and that a kind is never pending and in progress at the same time. Some behaviours need history that only the bench scenarios can show. These are: when a burst starts and stops, dropping a second request, the choice of request source, the second M1 of the multiframe burst, and realigning the internal counter.

// File: rtl/ds3_oh_errinj_pkg.sv
package ds3_oh_errinj_pkg;

    typedef enum logic [1:0] {
        FR_FBIT  = 2'd0,
        FR_MBIT  = 2'd1,
        FR_SEF   = 2'd2,
        FR_OOMF  = 2'd3
    } fr_mode_e;

    localparam int KIND_FR = 0;
    localparam int KIND_P  = 1;
    localparam int KIND_C  = 2;
    localparam int KIND_FB = 3;
    localparam int NKIND   = 4;

    localparam int SUB_P1   = 2;
    localparam int SUB_P2   = 3;
    localparam int SUB_M1   = 4;
    localparam int SUB_CPAR = 2;
    localparam int SUB_FEBE = 3;

    typedef struct packed {
        logic is_f;
        logic f_first;
        logic f_last;
        logic is_m;
        logic m_first;
        logic is_p;
        logic p_first;
        logic p_last;
        logic is_c3;
        logic c3_first;
        logic c3_last;
        logic is_c4;
        logic c4_first;
        logic c4_last;
    } opp_t;

endpackage

// File: rtl/ds3_oh_pos_gen.sv
module ds3_oh_pos_gen #(
    parameter int SUBS     = 7,
    parameter int BLKS     = 8,
    parameter int BLK_BITS = 85,
    localparam int SUB_W   = $clog2(SUBS),
    localparam int BLK_W   = $clog2(BLKS),
    localparam int BIT_W   = $clog2(BLK_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_sync,
    input  logic             ext_en,
    input  logic [SUB_W-1:0] ext_sub,
    input  logic [BLK_W-1:0] ext_blk,
    input  logic [BIT_W-1:0] ext_bit,
    output logic [SUB_W-1:0] cur_sub,
    output logic [BLK_W-1:0] cur_blk,
    output logic [BIT_W-1:0] cur_bit
);

    typedef struct packed {
        logic [SUB_W-1:0] sub;
        logic [BLK_W-1:0] blk;
        logic [BIT_W-1:0] bitn;
    } pos_t;

    pos_t cnt_q, cnt_d, base;

    always_comb begin
        base  = frame_sync ? '0 : cnt_q;
        cnt_d = base;
        if (base.bitn == BIT_W'(BLK_BITS - 1)) begin
            cnt_d.bitn = '0;
            if (base.blk == BLK_W'(BLKS - 1)) begin
                cnt_d.blk = '0;
                if (base.sub == SUB_W'(SUBS - 1)) begin
                    cnt_d.sub = '0;
                end else begin
                    cnt_d.sub = base.sub + 1'b1;
                end
            end else begin
                cnt_d.blk = base.blk + 1'b1;
            end
        end else begin
            cnt_d.bitn = base.bitn + 1'b1;
        end
        cur_sub = ext_en ? ext_sub : base.sub;
        cur_blk = ext_en ? ext_blk : base.blk;
        cur_bit = ext_en ? ext_bit : base.bitn;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/ds3_oh_opp_decode.sv
module ds3_oh_opp_decode
    import ds3_oh_errinj_pkg::*;
#(
    parameter int SUBS     = 7,
    parameter int BLKS     = 8,
    parameter int BLK_BITS = 85,
    localparam int SUB_W   = $clog2(SUBS),
    localparam int BLK_W   = $clog2(BLKS),
    localparam int BIT_W   = $clog2(BLK_BITS)
) (
    input  logic [SUB_W-1:0] sub,
    input  logic [BLK_W-1:0] blk,
    input  logic [BIT_W-1:0] bitn,
    output opp_t             opp
);

    logic oh, blk0, cblk, cfirst, clast;

    always_comb begin
        oh     = (bitn == '0);
        blk0   = oh && (blk == '0);
        cblk   = oh && (blk != '0) && !blk[0];
        cfirst = (blk == BLK_W'(2));
        clast  = (blk == BLK_W'(BLKS - 2));

        opp          = '0;
        opp.is_f     = oh && blk[0];
        opp.f_first  = opp.is_f && (blk == BLK_W'(1));
        opp.f_last   = opp.is_f && (blk == BLK_W'(BLKS - 1));
        opp.is_m     = blk0 && (sub >= SUB_W'(SUB_M1));
        opp.m_first  = blk0 && (sub == SUB_W'(SUB_M1));
        opp.p_first  = blk0 && (sub == SUB_W'(SUB_P1));
        opp.p_last   = blk0 && (sub == SUB_W'(SUB_P2));
        opp.is_p     = opp.p_first || opp.p_last;
        opp.is_c3    = cblk && (sub == SUB_W'(SUB_CPAR));
        opp.c3_first = opp.is_c3 && cfirst;
        opp.c3_last  = opp.is_c3 && clast;
        opp.is_c4    = cblk && (sub == SUB_W'(SUB_FEBE));
        opp.c4_first = opp.is_c4 && cfirst;
        opp.c4_last  = opp.is_c4 && clast;
    end

endmodule

// File: rtl/ds3_oh_req_ctrl.sv
module ds3_oh_req_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       cont,
    input  logic       req_edge,
    input  logic       first,
    input  logic       member,
    input  logic       last,
    input  logic [1:0] groups,
    output logic       hit,
    output logic       pend,
    output logic       act
);

    typedef struct packed {
        logic       pend;
        logic       act;
        logic [1:0] left;
    } st_t;

    st_t        s_q, s_d;
    logic       starting, live;
    logic [1:0] left_now;

    always_comb begin
        starting = s_q.pend && first;
        live     = s_q.act || starting;
        hit      = en && (cont ? member : (live && member));
        left_now = starting ? groups : s_q.left;
        s_d      = s_q;
        if (!en || cont) begin
            s_d = '0;
        end else begin
            if (starting) begin
                s_d.pend = 1'b0;
                s_d.act  = 1'b1;
                s_d.left = groups;
            end
            if (live && last) begin
                s_d.left = left_now - 1'b1;
                if (left_now == 2'd1) begin
                    s_d.act = 1'b0;
                end
            end
            if (req_edge && !s_q.pend && !s_q.act) begin
                s_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pend = s_q.pend;
    assign act  = s_q.act;

endmodule

// File: rtl/ds3_oh_errinj.sv
module ds3_oh_errinj
    import ds3_oh_errinj_pkg::*;
#(
    parameter int SUBS     = 7,
    parameter int BLKS     = 8,
    parameter int BLK_BITS = 85,
    localparam int SUB_W   = $clog2(SUBS),
    localparam int BLK_W   = $clog2(BLKS),
    localparam int BIT_W   = $clog2(BLK_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic             ext_pos_en,
    input  logic [SUB_W-1:0] ext_sub,
    input  logic [BLK_W-1:0] ext_blk,
    input  logic [BIT_W-1:0] ext_bit,
    input  logic             frame_sync,
    input  logic [3:0]       err_en,
    input  logic [3:0]       err_cont,
    input  logic [1:0]       fr_mode,
    input  logic             req_src_sel,
    input  logic [3:0]       reg_req,
    input  logic             man_req,
    output logic             dout
);

    typedef struct packed {
        logic [NKIND-1:0] prev;
        logic             dout;
    } top_t;

    top_t             st_q, st_d;
    logic [SUB_W-1:0] cur_sub;
    logic [BLK_W-1:0] cur_blk;
    logic [BIT_W-1:0] cur_bit;
    opp_t             opp;
    logic [NKIND-1:0] req_lvl, req_edge;
    logic [NKIND-1:0] first_v, member_v, last_v;
    logic [1:0]       groups_v [NKIND];
    logic [NKIND-1:0] hit, pend, act;
    fr_mode_e         fmode;

    ds3_oh_pos_gen #(.SUBS(SUBS), .BLKS(BLKS), .BLK_BITS(BLK_BITS)) pos_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .ext_en     (ext_pos_en),
        .ext_sub    (ext_sub),
        .ext_blk    (ext_blk),
        .ext_bit    (ext_bit),
        .cur_sub    (cur_sub),
        .cur_blk    (cur_blk),
        .cur_bit    (cur_bit)
    );

    ds3_oh_opp_decode #(.SUBS(SUBS), .BLKS(BLKS), .BLK_BITS(BLK_BITS)) dec_i (
        .sub  (cur_sub),
        .blk  (cur_blk),
        .bitn (cur_bit),
        .opp  (opp)
    );

    always_comb begin
        fmode    = fr_mode_e'(fr_mode);
        req_lvl  = req_src_sel ? {NKIND{man_req}} : reg_req;
        req_edge = req_lvl & ~st_q.prev;

        for (int k = 0; k < NKIND; k++) begin
            groups_v[k] = 2'd1;
        end
        unique case (fmode)
            FR_FBIT: begin
                first_v[KIND_FR]  = opp.is_f;
                member_v[KIND_FR] = opp.is_f;
                last_v[KIND_FR]   = opp.is_f;
            end
            FR_MBIT: begin
                first_v[KIND_FR]  = opp.is_m;
                member_v[KIND_FR] = opp.is_m;
                last_v[KIND_FR]   = opp.is_m;
            end
            FR_SEF: begin
                first_v[KIND_FR]  = opp.f_first;
                member_v[KIND_FR] = opp.is_f;
                last_v[KIND_FR]   = opp.f_last;
            end
            default: begin
                first_v[KIND_FR]  = opp.m_first;
                member_v[KIND_FR] = opp.m_first;
                last_v[KIND_FR]   = opp.m_first;
                groups_v[KIND_FR] = 2'd2;
            end
        endcase
        first_v[KIND_P]  = opp.p_first;
        member_v[KIND_P] = opp.is_p;
        last_v[KIND_P]   = opp.p_last;
        first_v[KIND_C]  = opp.c3_first;
        member_v[KIND_C] = opp.is_c3;
        last_v[KIND_C]   = opp.c3_last;
        first_v[KIND_FB]  = opp.c4_first;
        member_v[KIND_FB] = opp.is_c4;
        last_v[KIND_FB]   = opp.c4_last;
    end

    for (genvar k = 0; k < NKIND; k++) begin : g_kind
        ds3_oh_req_ctrl ctl_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (err_en[k]),
            .cont     (err_cont[k]),
            .req_edge (req_edge[k]),
            .first    (first_v[k]),
            .member   (member_v[k]),
            .last     (last_v[k]),
            .groups   (groups_v[k]),
            .hit      (hit[k]),
            .pend     (pend[k]),
            .act      (act[k])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.prev = req_lvl;
        if (hit[KIND_FB]) begin
            st_d.dout = 1'b0;
        end else begin
            st_d.dout = din ^ (hit[KIND_FR] | hit[KIND_P] | hit[KIND_C]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.dout;

endmodule

// File: rtl/ds3_oh_errinj_chk.sv
module ds3_oh_errinj_chk
    import ds3_oh_errinj_pkg::*;
#(
    parameter int BIT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             din,
    input logic             dout,
    input logic [BIT_W-1:0] cur_bit,
    input logic [3:0]       hit,
    input logic [3:0]       pend,
    input logic [3:0]       act,
    input logic [3:0]       err_en,
    input logic [3:0]       err_cont,
    input opp_t             opp
);

    assert_payload_pass_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_bit != '0) |=> (dout == $past(din)));

    assert_febe_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit[KIND_FB] |=> !dout);

    assert_pbit_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit[KIND_P] |=> (dout != $past(din)));

    assert_cont_every_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_en[KIND_P] && err_cont[KIND_P] && opp.is_p) |=> (dout != $past(din)));

    assert_all_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_en == 4'b0000) |=> (dout == $past(din)));

    assert_pend_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & act) == 4'b0000);

endmodule

bind ds3_oh_errinj ds3_oh_errinj_chk #(.BIT_W(BIT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (din),
    .dout     (dout),
    .cur_bit  (cur_bit),
    .hit      (hit),
    .pend     (pend),
    .act      (act),
    .err_en   (err_en),
    .err_cont (err_cont),
    .opp      (opp)
);

// File: tb/ds3_oh_errinj_tb.sv
module ds3_oh_errinj_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       din = 1'b0;
    logic       ext_pos_en = 1'b1;
    logic [2:0] ext_sub = '0;
    logic [2:0] ext_blk = '0;
    logic [6:0] ext_bit = 7'd5;
    logic       frame_sync = 1'b0;
    logic [3:0] err_en = '0;
    logic [3:0] err_cont = '0;
    logic [1:0] fr_mode = '0;
    logic       req_src_sel = 1'b0;
    logic [3:0] reg_req = '0;
    logic       man_req = 1'b0;
    logic       dout;

    int n_chk = 0;
    int n_fail = 0;
    logic got;

    always #(CLK_PERIOD/2) clk = ~clk;

    ds3_oh_errinj dut_i (
        .clk(clk), .rst_n(rst_n), .din(din), .ext_pos_en(ext_pos_en),
        .ext_sub(ext_sub), .ext_blk(ext_blk), .ext_bit(ext_bit),
        .frame_sync(frame_sync), .err_en(err_en), .err_cont(err_cont),
        .fr_mode(fr_mode), .req_src_sel(req_src_sel), .reg_req(reg_req),
        .man_req(man_req), .dout(dout)
    );

    typedef struct packed {
        logic [2:0] sub;
        logic [2:0] blk;
        logic [6:0] bitn;
        logic       d;
        logic       exp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{sub:3'd0, blk:3'd1, bitn:7'd0,  d:1'b1, exp:1'b0},
        '{sub:3'd0, blk:3'd0, bitn:7'd0,  d:1'b1, exp:1'b1},
        '{sub:3'd2, blk:3'd0, bitn:7'd0,  d:1'b0, exp:1'b1},
        '{sub:3'd3, blk:3'd0, bitn:7'd0,  d:1'b1, exp:1'b0},
        '{sub:3'd2, blk:3'd4, bitn:7'd0,  d:1'b0, exp:1'b1},
        '{sub:3'd3, blk:3'd6, bitn:7'd0,  d:1'b1, exp:1'b0},
        '{sub:3'd4, blk:3'd0, bitn:7'd0,  d:1'b1, exp:1'b1},
        '{sub:3'd1, blk:3'd2, bitn:7'd0,  d:1'b1, exp:1'b1},
        '{sub:3'd5, blk:3'd3, bitn:7'd40, d:1'b1, exp:1'b1},
        '{sub:3'd6, blk:3'd7, bitn:7'd0,  d:1'b0, exp:1'b1}
    };

    task automatic check(input string req, input logic act_v, input logic exp_v);
        n_chk++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act_v, exp_v);
        end
    endtask

    // drive one bit at a position; returns dout for that bit
    task automatic step(input int s, input int b, input int t, input logic d, output logic o);
        ext_sub = 3'(s);
        ext_blk = 3'(b);
        ext_bit = 7'(t);
        din     = d;
        @(negedge clk);
        o = dout;
    endtask

    task automatic idle(input int n);
        logic o;
        for (int i = 0; i < n; i++) step(0, 2, 10, 1'b0, o);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        reg_req = '0;
        man_req = 1'b0;
        req_src_sel = 1'b0;
        err_en = '0;
        err_cont = '0;
        fr_mode = '0;
        ext_pos_en = 1'b1;
        frame_sync = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic pulse_reg(input int k);
        reg_req[k] = 1'b1;
        idle(1);
        reg_req[k] = 1'b0;
        idle(1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic o;
        int errs;
        @(negedge clk);
        @(negedge clk);
        check("R13 reset dout", dout, 1'b0);

        // R8: continuous table, framing in F-bit mode
        do_reset();
        err_en = 4'b1111;
        err_cont = 4'b1111;
        fr_mode = 2'd0;
        for (int i = 0; i < NV; i++) begin
            step(VECS[i].sub, VECS[i].blk, VECS[i].bitn, VECS[i].d, o);
            check($sformatf("R8 vector %0d", i), o, VECS[i].exp);
        end

        // R11: enable off, continuous set
        do_reset();
        err_cont = 4'b1111;
        step(2, 0, 0, 1'b0, o); check("R11 P1 disabled", o, 1'b0);
        step(3, 4, 0, 1'b1, o); check("R11 C42 disabled", o, 1'b1);

        // R5 and R10: single P-bit error, second request ignored
        do_reset();
        err_en[1] = 1'b1;
        pulse_reg(1);
        pulse_reg(1);
        step(2, 0, 0, 1'b0, o); check("R5 P1 inverted", o, 1'b1);
        step(3, 0, 0, 1'b1, o); check("R5 P2 inverted", o, 1'b0);
        step(2, 0, 0, 1'b0, o); check("R10 second request ignored", o, 1'b0);

        // R9: manual source selected, register pulse has no effect
        do_reset();
        err_en[1] = 1'b1;
        req_src_sel = 1'b1;
        pulse_reg(1);
        step(2, 0, 0, 1'b0, o); check("R9 reg ignored", o, 1'b0);
        step(3, 0, 0, 1'b0, o);
        man_req = 1'b1; idle(1); man_req = 1'b0; idle(1);
        step(2, 0, 0, 1'b0, o); check("R9 manual P1", o, 1'b1);

        // R6: single C-bit parity error
        do_reset();
        err_en[2] = 1'b1;
        pulse_reg(2);
        step(2, 2, 0, 1'b0, o); check("R6 C31", o, 1'b1);
        step(2, 4, 0, 1'b1, o); check("R6 C32", o, 1'b0);
        step(2, 6, 0, 1'b0, o); check("R6 C33", o, 1'b1);
        step(2, 2, 0, 1'b0, o); check("R6 next frame clean", o, 1'b0);

        // R7: single far-end block error
        do_reset();
        err_en[3] = 1'b1;
        pulse_reg(3);
        step(3, 2, 0, 1'b1, o); check("R7 C41", o, 1'b0);
        step(3, 4, 0, 1'b1, o); check("R7 C42", o, 1'b0);
        step(3, 6, 0, 1'b1, o); check("R7 C43", o, 1'b0);
        step(3, 2, 0, 1'b1, o); check("R7 next frame clean", o, 1'b1);

        // R1: single F-bit
        do_reset();
        err_en[0] = 1'b1;
        fr_mode = 2'd0;
        pulse_reg(0);
        step(1, 5, 0, 1'b1, o); check("R1 F inverted", o, 1'b0);
        step(1, 7, 0, 1'b1, o); check("R1 following F clean", o, 1'b1);

        // R2: single M-bit
        do_reset();
        err_en[0] = 1'b1;
        fr_mode = 2'd1;
        pulse_reg(0);
        step(5, 0, 0, 1'b0, o); check("R2 M2 inverted", o, 1'b1);
        step(6, 0, 0, 1'b0, o); check("R2 M3 clean", o, 1'b0);

        // R3: subframe burst
        do_reset();
        err_en[0] = 1'b1;
        fr_mode = 2'd2;
        pulse_reg(0);
        step(0, 3, 0, 1'b1, o); check("R3 F before F1 clean", o, 1'b1);
        for (int b = 1; b < 8; b += 2) begin
            step(1, b, 0, 1'b1, o);
            check($sformatf("R3 F blk %0d", b), o, 1'b0);
        end
        step(2, 1, 0, 1'b1, o); check("R3 after burst clean", o, 1'b1);

        // R4: multiframe burst
        do_reset();
        err_en[0] = 1'b1;
        fr_mode = 2'd3;
        pulse_reg(0);
        step(4, 0, 0, 1'b1, o); check("R4 first M1", o, 1'b0);
        step(5, 0, 0, 1'b1, o); check("R4 M2 clean", o, 1'b1);
        step(4, 0, 0, 1'b1, o); check("R4 second M1", o, 1'b0);
        step(4, 0, 0, 1'b1, o); check("R4 third M1 clean", o, 1'b1);

        // R12: internal counter after frame sync, continuous F-bit
        do_reset();
        err_en[0] = 1'b1;
        err_cont[0] = 1'b1;
        fr_mode = 2'd0;
        ext_pos_en = 1'b0;
        errs = 0;
        for (int k = 0; k < 170; k++) begin
            frame_sync = (k == 0);
            step(0, 0, 5, 1'b1, o);
            if (o !== ((k == 85) ? 1'b0 : 1'b1)) errs++;
        end
        frame_sync = 1'b0;
        check("R12 internal counter F position", errs == 0, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule